// File: doc/BRIEF.md
# Serial Programming Link Host Controller

This block sits on the host side of a three-wire serial programming link and prepares a microcontroller target for in-system programming. After reset it runs an entry sequence. The target reset line and the serial clock are first held low. The reset line then gets a short high pulse, returns low, and the block waits a fixed 20 ms that is counted exactly in host clock cycles. Only after that wait does the block accept work.

Each piece of work is one 32-bit instruction, offered through a single-cycle request strobe. The block moves it to the target over the serial data-out line, most significant bit first, on a clock it generates itself. The length of each clock phase comes from a configuration input, with a floor that keeps both phases long enough for a fast target. The block gathers the bits the target returns and presents the last of the four received bytes as the response. A busy flag covers the whole transfer, and requests that arrive while the block is busy or before entry is done are dropped.

Top module: `prog_link_host`

## Requirements
- R1: While rst_n is low and in the first cycle after it, tgtReset, sck, ready and busy are all 0.
- R2: After reset, sck stays 0 for the whole entry sequence. tgtReset is first held 0 for LOW_CYCLES cycles and then driven 1 for exactly PULSE_CYCLES host cycles, where PULSE_CYCLES is at least 2.
- R3: After tgtReset falls, ready rises after exactly HOST_CLK_HZ/1000*WAIT_MS host cycles (20 ms by default) and then stays 1.
- R4: A transfer drives all 32 bits of reqInstr onto mosi, bit 31 first. mosi changes only while sck is low, so the target sees bit 31-k on the (k+1)-th rising edge of sck.
- R5: miso is sampled when sck rises. After the transfer, respData holds the last 8 bits received, with the first of those 8 bits in respData[7].
- R6: Each low phase and each high phase of sck lasts max(cfgHalfDiv, MIN_HALF) host cycles. A transfer has exactly 32 rising edges, and sck rests at 0 when idle.
- R7: When cfgHalfDiv is below MIN_HALF (default 3), the phase length is raised to MIN_HALF.
- R8: busy rises in the cycle after an accepted request and stays high for exactly 64 phase lengths. respValid pulses for one cycle as busy falls, and a request made while busy is ignored.
- R9: A request made before ready is 1 is ignored: it starts no sck activity and does not raise busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfgHalfDiv | input | DIV_W | Requested sck phase length in host cycles |
| reqValid | input | 1 | Single-cycle request strobe |
| reqInstr | input | 32 | Instruction to send |
| ready | output | 1 | Entry sequence finished; requests are accepted |
| busy | output | 1 | Transfer in progress |
| respValid | output | 1 | One-cycle pulse when respData is valid |
| respData | output | 8 | Fourth received byte |
| sck | output | 1 | Serial clock to the target |
| mosi | output | 1 | Serial data to the target |
| miso | input | 1 | Serial data from the target |
| tgtReset | output | 1 | Target reset line |

## Verification
Some properties are checked by assertions on every cycle. sck rests low whenever no transfer is active. The phase counter never reaches the effective phase length. The reset line stays low during transfers. A transfer only starts after entry has finished. mosi holds steady while sck is high, and respValid never lasts more than one cycle. Other properties need the bench's scenarios with a bit-level target model: the exact lengths of the reset pulse and the 20 ms wait, the bit order and content seen by the target, the phase durations including the raised minimum, the busy window length, and the dropping of early and overlapping requests.

// File: rtl/isp_host_pkg.sv
package isp_host_pkg;

  // Strobes from control to datapath, one per host cycle
  typedef struct packed {
    logic load;    // capture new instruction
    logic sample;  // sck about to rise: take miso
    logic shift;   // sck about to fall: advance mosi
  } xferStrobe_t;

  typedef enum logic [2:0] {
    ST_LOW,
    ST_PULSE,
    ST_WAIT,
    ST_IDLE,
    ST_XFER
  } seqState_t;

endpackage

// File: rtl/isp_host_ctrl.sv
module isp_host_ctrl
  import isp_host_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int MIN_HALF    = 3,
  parameter int LOW_CYCLES  = 4,
  parameter int PULSE_CYCLES = 4,
  parameter int WAIT_CYCLES = 20000,
  parameter int NUM_BITS    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] cfgHalfDiv,
  input  logic             reqValid,
  output xferStrobe_t      strobe,
  output logic             sck,
  output logic             tgtReset,
  output logic             ready,
  output logic             busy,
  output logic             respValid
);

  localparam int LONGEST = (WAIT_CYCLES > PULSE_CYCLES) ?
                           ((WAIT_CYCLES > LOW_CYCLES) ? WAIT_CYCLES : LOW_CYCLES) :
                           ((PULSE_CYCLES > LOW_CYCLES) ? PULSE_CYCLES : LOW_CYCLES);
  localparam int TMR_W = $clog2(LONGEST + 1);
  localparam int BIT_W = $clog2(NUM_BITS);
  localparam logic [TMR_W-1:0] LOW_END   = TMR_W'(LOW_CYCLES - 1);
  localparam logic [TMR_W-1:0] PULSE_END = TMR_W'(PULSE_CYCLES - 1);
  localparam logic [TMR_W-1:0] WAIT_END  = TMR_W'(WAIT_CYCLES - 1);
  localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(NUM_BITS - 1);
  localparam logic [DIV_W-1:0] MIN_DIV   = DIV_W'(MIN_HALF);

  seqState_t         state;
  logic [TMR_W-1:0]  timer;
  logic [DIV_W-1:0]  phaseCnt;
  logic [BIT_W-1:0]  bitCnt;
  logic [DIV_W-1:0]  halfEff;
  logic              phaseEnd;

  // Raise short phases to the floor for fast targets
  always_comb begin
    halfEff  = (cfgHalfDiv < MIN_DIV) ? MIN_DIV : cfgHalfDiv;
    phaseEnd = (state == ST_XFER) && (phaseCnt == halfEff - 1'b1);
    strobe.load   = (state == ST_IDLE) && reqValid;
    strobe.sample = phaseEnd && !sck;
    strobe.shift  = phaseEnd && sck && (bitCnt != LAST_BIT);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_LOW;
      timer     <= '0;
      phaseCnt  <= '0;
      bitCnt    <= '0;
      sck       <= 1'b0;
      tgtReset  <= 1'b0;
      ready     <= 1'b0;
      busy      <= 1'b0;
      respValid <= 1'b0;
    end else begin
      respValid <= 1'b0;
      unique case (state)
        ST_LOW: begin
          if (timer == LOW_END) begin
            timer    <= '0;
            tgtReset <= 1'b1;
            state    <= ST_PULSE;
          end else begin
            timer <= timer + 1'b1;
          end
        end
        ST_PULSE: begin
          if (timer == PULSE_END) begin
            timer    <= '0;
            tgtReset <= 1'b0;
            state    <= ST_WAIT;
          end else begin
            timer <= timer + 1'b1;
          end
        end
        ST_WAIT: begin
          if (timer == WAIT_END) begin
            timer <= '0;
            ready <= 1'b1;
            state <= ST_IDLE;
          end else begin
            timer <= timer + 1'b1;
          end
        end
        ST_IDLE: begin
          if (reqValid) begin
            busy     <= 1'b1;
            phaseCnt <= '0;
            bitCnt   <= '0;
            sck      <= 1'b0;
            state    <= ST_XFER;
          end
        end
        ST_XFER: begin
          if (phaseEnd) begin
            phaseCnt <= '0;
            sck      <= ~sck;
            if (sck) begin
              if (bitCnt == LAST_BIT) begin
                busy      <= 1'b0;
                respValid <= 1'b1;
                state     <= ST_IDLE;
              end else begin
                bitCnt <= bitCnt + 1'b1;
              end
            end
          end else begin
            phaseCnt <= phaseCnt + 1'b1;
          end
        end
        default: state <= ST_LOW;
      endcase
    end
  end

  assert_sck_rests_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sck);

  assert_phase_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    phaseCnt < halfEff);

  assert_reset_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !tgtReset);

  assert_start_after_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (ready && $past(ready)));

  assert_resp_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    respValid |=> !respValid);

endmodule

// File: rtl/isp_host_datapath.sv
module isp_host_datapath
  import isp_host_pkg::*;
#(
  parameter int NUM_BITS  = 32,
  parameter int RESP_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  xferStrobe_t          strobe,
  input  logic [NUM_BITS-1:0]  reqInstr,
  input  logic                 miso,
  output logic                 mosi,
  output logic [RESP_BITS-1:0] respData
);

  logic [NUM_BITS-1:0]  txShift;
  logic [RESP_BITS-1:0] rxShift;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      txShift <= '0;
      rxShift <= '0;
    end else begin
      if (strobe.load) begin
        txShift <= reqInstr;
        rxShift <= '0;
      end else begin
        if (strobe.shift)  txShift <= {txShift[NUM_BITS-2:0], 1'b0};
        if (strobe.sample) rxShift <= {rxShift[RESP_BITS-2:0], miso};
      end
    end
  end

  assign mosi     = txShift[NUM_BITS-1];
  assign respData = rxShift;

endmodule

// File: rtl/prog_link_host.sv
module prog_link_host
  import isp_host_pkg::*;
#(
  parameter int HOST_CLK_HZ  = 1_000_000,
  parameter int WAIT_MS      = 20,
  parameter int DIV_W        = 8,
  parameter int MIN_HALF     = 3,
  parameter int LOW_CYCLES   = 4,
  parameter int PULSE_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] cfgHalfDiv,
  input  logic             reqValid,
  input  logic [31:0]      reqInstr,
  output logic             ready,
  output logic             busy,
  output logic             respValid,
  output logic [7:0]       respData,
  output logic             sck,
  output logic             mosi,
  input  logic             miso,
  output logic             tgtReset
);

  localparam int WAIT_CYCLES = HOST_CLK_HZ / 1000 * WAIT_MS;

  xferStrobe_t strobe;

  isp_host_ctrl #(
    .DIV_W(DIV_W), .MIN_HALF(MIN_HALF), .LOW_CYCLES(LOW_CYCLES),
    .PULSE_CYCLES(PULSE_CYCLES), .WAIT_CYCLES(WAIT_CYCLES), .NUM_BITS(32)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfgHalfDiv(cfgHalfDiv), .reqValid(reqValid),
    .strobe(strobe), .sck(sck), .tgtReset(tgtReset), .ready(ready),
    .busy(busy), .respValid(respValid)
  );

  isp_host_datapath #(.NUM_BITS(32), .RESP_BITS(8)) u_data (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .reqInstr(reqInstr),
    .miso(miso), .mosi(mosi), .respData(respData)
  );

  // Data must be settled while the target samples on the high phase
  assert_mosi_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(mosi));

endmodule

// File: tb/prog_link_host_tb.sv
module prog_link_host_tb;

  localparam int CLK_PERIOD = 10;
  localparam int HZ         = 200_000;
  localparam int WAIT_MS    = 20;
  localparam int WAIT_CYC   = HZ / 1000 * WAIT_MS;
  localparam int MIN_H      = 3;
  localparam int PULSE      = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] cfgHalfDiv = 8'd4;
  logic       reqValid = 1'b0;
  logic [31:0] reqInstr = '0;
  logic       ready, busy, respValid, sck, mosi, tgtReset;
  logic [7:0] respData;
  logic       misoReg = 1'b0;

  int testCnt = 0;
  int failCnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prog_link_host #(.HOST_CLK_HZ(HZ), .WAIT_MS(WAIT_MS), .MIN_HALF(MIN_H),
                   .PULSE_CYCLES(PULSE)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfgHalfDiv(cfgHalfDiv), .reqValid(reqValid),
    .reqInstr(reqInstr), .ready(ready), .busy(busy), .respValid(respValid),
    .respData(respData), .sck(sck), .mosi(mosi), .miso(misoReg),
    .tgtReset(tgtReset)
  );

  // Target model: takes mosi on rising sck, drives miso on falling sck
  logic [31:0] tgtIn = '0;
  logic [31:0] tgtPat = '0;
  int          tgtEdges = 0;
  always @(posedge sck) begin
    tgtIn    = {tgtIn[30:0], mosi};
    tgtEdges = tgtEdges + 1;
  end
  always @(negedge sck) begin
    if (tgtEdges < 32) misoReg = tgtPat[31 - tgtEdges];
  end

  // Phase and handshake monitor, sampled away from the active edge
  logic prevSck = 1'b0;
  int runLen = 0, minHi = 0, maxHi = 0, minLo = 0, maxLo = 0;
  int busyCyc = 0, respCnt = 0;
  logic [7:0] lastResp = '0;
  always @(negedge clk) begin
    if (sck != prevSck) begin
      if (prevSck) begin
        if (runLen < minHi) minHi = runLen;
        if (runLen > maxHi) maxHi = runLen;
      end else begin
        if (runLen < minLo) minLo = runLen;
        if (runLen > maxLo) maxLo = runLen;
      end
      runLen = 1;
    end else begin
      runLen = runLen + 1;
    end
    if (!busy) runLen = 0;
    prevSck = sck;
    if (busy) busyCyc = busyCyc + 1;
    if (respValid) begin
      respCnt  = respCnt + 1;
      lastResp = respData;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  // R1, R2, R3, R9: reset state, entry pulse, exact wait, early request dropped
  task automatic testEntry();
    int pulseLen = 0, waitLen = 0, sckHigh = 0, activity = 0;
    bit pulseDone = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(tgtReset == 1'b0, "R1 tgtReset", tgtReset, 0);
    check(sck == 1'b0, "R1 sck", sck, 0);
    check(ready == 1'b0, "R1 ready", ready, 0);
    check(busy == 1'b0, "R1 busy", busy, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(tgtReset == 1'b0 && ready == 1'b0, "R1 first cycle", {tgtReset, ready}, 0);
    for (int i = 0; i < WAIT_CYC + 100; i++) begin
      if (sck) sckHigh++;
      if (busy) activity++;
      if (tgtReset) pulseLen++;
      else if (pulseLen > 0) pulseDone = 1;
      if (pulseDone && !ready) waitLen++;
      reqValid = (pulseDone && waitLen > 10 && waitLen < 20);
      reqInstr = 32'hFFFF_FFFF;
      if (ready) break;
      @(negedge clk);
    end
    reqValid = 1'b0;
    check(pulseLen == PULSE, "R2 pulse length", pulseLen, PULSE);
    check(sckHigh == 0, "R2 sck low during entry", sckHigh, 0);
    check(waitLen == WAIT_CYC, "R3 wait length", waitLen, WAIT_CYC);
    check(activity == 0 && tgtEdges == 0, "R9 early request ignored", activity + tgtEdges, 0);
    repeat (5) @(negedge clk);
    check(ready == 1'b1 && busy == 1'b0 && tgtEdges == 0, "R3 ready held / R9 no start",
          {ready, busy}, 2);
  endtask

  // R4, R5, R6, R7, R8: one full transfer, optional overlapping request
  task automatic testXfer(input logic [31:0] instr, input logic [31:0] pat,
                          input logic [7:0] half, input bit overlap, input string tag);
    int expH = (half < MIN_H) ? MIN_H : half;
    cfgHalfDiv = half;
    tgtPat = pat; tgtIn = '0; tgtEdges = 0; misoReg = pat[31];
    minHi = 1000; maxHi = 0; minLo = 1000; maxLo = 0;
    busyCyc = 0; respCnt = 0;
    reqInstr = instr; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    check(busy == 1'b1, {tag, " R8 busy rises"}, busy, 1);
    if (overlap) begin
      repeat (7) @(negedge clk);
      reqInstr = ~instr; reqValid = 1'b1;
      @(negedge clk);
      reqValid = 1'b0;
    end
    for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
    repeat (3 * expH) @(negedge clk);
    check(tgtIn == instr, {tag, " R4 target received"}, tgtIn, instr);
    check(tgtEdges == 32, {tag, " R6 rising edges"}, tgtEdges, 32);
    check(lastResp == pat[7:0], {tag, " R5 response byte"}, lastResp, pat[7:0]);
    check(minHi == expH && maxHi == expH, {tag, " R6 R7 high phase"}, maxHi, expH);
    check(minLo == expH && maxLo == expH, {tag, " R6 R7 low phase"}, maxLo, expH);
    check(busyCyc == 64 * expH, {tag, " R8 busy window"}, busyCyc, 64 * expH);
    check(respCnt == 1, {tag, " R8 one response pulse"}, respCnt, 1);
    check(sck == 1'b0 && busy == 1'b0, {tag, " R6 idle level"}, {sck, busy}, 0);
  endtask

  initial begin : watchdog
    repeat (150_000) @(posedge clk);
    testCnt++; failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    testEntry();
    testXfer(32'hAC53_0000, 32'h1234_5653, 8'd4, 1'b0, "base");
    testXfer(32'h3000_0102, 32'hFFFF_FF1E, 8'd1, 1'b0, "clamp");
    testXfer(32'h8001_7F80, 32'h0055_AAC3, 8'd6, 1'b1, "overlap");
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule